// File: doc/BRIEF.md
# Shared Register-Port Priority Arbiter

This block lets several execution units share one register-file read port and one register-file write port. Each port has a single broadcast bus that every unit attaches to. A unit raises a request for the port it needs, and a fixed-priority picker grants exactly one requester per port in each cycle. The granted unit's address and data reach the bus through an OR-reduction tree rather than a multiplexer, so every unit that is not granted is masked to zero before the tree.

The read port is combinational. In the same cycle as the request, the grant, the register address, the read enable and the read data are all valid. The write port is registered. One clock after the request, the write enable, the write address, the write data and the per-unit write-go strobe all appear together. The register file is a small behavioural array held inside the block, and it stores data on the edge where the registered write enable is high.

The block does no hazard analysis and has no bypass path. The surrounding issue logic is expected to let only one unit operate at a time. A unit that is not granted holds its request until it is granted.

Top module: `regport_share_arb`

## Requirements
- R1: While the synchronous active-low reset is asserted, all registered write-side outputs (`wr_go`, `rf_wr_en`, `rf_wr_addr`, `rf_wr_data`) are zero, whatever the requests are. After reset, every register-file entry reads as zero.
- R2: `rd_gnt` is combinational. Bit i is set only when `rd_req[i]` is set and no lower-numbered bit of `rd_req` is set, so unit 0 has the highest priority. `rd_gnt` is all-zero when there is no read request.
- R3: `wr_go` is registered. One cycle after `wr_req` is sampled, it equals the lowest-numbered set bit of that `wr_req` as a one-hot vector. It is all-zero if `wr_req` was zero.
- R4: `rf_rd_en` is high exactly when some read request is present. `rf_rd_addr` is the address field of the granted unit (unit i's field is `rd_addr_in[i*ADDR_W +: ADDR_W]`), and it is zero when nothing is granted.
- R5: `rd_data` is the register-file content at `rf_rd_addr` when `rf_rd_en` is high, and zero otherwise.
- R6: `rf_wr_en`, `rf_wr_addr`, `rf_wr_data` and `wr_go` change on the same clock edge. `rf_wr_en` is high exactly when `wr_go` is non-zero. The address and data are the fields of the unit that won the write pick (unit i's data is `wr_data_in[i*DATA_W +: DATA_W]`), and they are zero when no unit was picked.
- R7: Data written by a request in cycle t can be read through the read port from cycle t+2. A read in cycle t+1 still returns the previous content.
- R8: The address and data of units that were not granted have no effect on `rf_rd_addr`, `rd_data`, `rf_wr_addr` or `rf_wr_data`.
- R9: A unit that holds its request while lower-numbered units drop theirs after being granted is granted in the first cycle in which it is the lowest-numbered requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | N_UNITS | Per-unit read-port request |
| rd_addr_in | input | N_UNITS*ADDR_W | Per-unit read address, unit i in bits [i*ADDR_W +: ADDR_W] |
| rd_gnt | output | N_UNITS | One-hot read grant (combinational) |
| rf_rd_en | output | 1 | Read enable on the register file |
| rf_rd_addr | output | ADDR_W | Merged read address |
| rd_data | output | DATA_W | Read data broadcast to all units |
| wr_req | input | N_UNITS | Per-unit write-port request |
| wr_addr_in | input | N_UNITS*ADDR_W | Per-unit write address |
| wr_data_in | input | N_UNITS*DATA_W | Per-unit write data |
| wr_go | output | N_UNITS | Registered one-hot write-go strobe |
| rf_wr_en | output | 1 | Registered write enable |
| rf_wr_addr | output | ADDR_W | Registered merged write address |
| rf_wr_data | output | DATA_W | Registered merged write data |

## Verification
The hardest case to reach from the ports is a low-priority unit waiting behind every higher unit while non-granted units keep driving conflicting data. In that case a broken mask would corrupt the OR-tree without changing any grant. The bench reaches it by raising all write requests at once with distinct data and retiring each unit only when it is granted, and it also uses random traffic in which non-granted fields carry random values. A write followed at once by a read of the same register checks the one-cycle window where the old content must still be returned.

// File: rtl/regport_pkg.sv
// Package: default sizes shared by the register-port arbiter and its bench.
// Assumes: all users take these as parameter defaults only.
package regport_pkg;
    parameter int unsigned RP_N_UNITS = 4;   // execution units on each port
    parameter int unsigned RP_ADDR_W  = 3;   // register address width
    parameter int unsigned RP_DATA_W  = 16;  // register data width
endpackage

// File: rtl/rp_prio_pick.sv
// Module: fixed-priority picker. Grants the lowest-indexed set request bit.
// Assumes: N >= 1. The output is purely combinational and one-hot or zero.
module rp_prio_pick #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // seen[i] is high when any request below index i is set
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_chain
            // propagate "a higher-priority unit already asked" up the chain
            assign seen[i+1] = seen[i] | req[i];
            // grant only the first requester in the chain
            assign gnt[i]    = req[i] & ~seen[i];
        end
    endgenerate

    assign any = seen[N];
endmodule

// File: rtl/rp_or_merge.sv
// Module: masked OR-reduction tree for a broadcast bus.
// Each lane is ANDed with its grant bit, and the lanes are then combined by a
// balanced binary OR tree. Assumes: at most one grant bit is set.
module rp_or_merge #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 8
) (
    input  logic [N*W-1:0] lanes,
    input  logic [N-1:0]   sel,
    output logic [W-1:0]   merged
);
    localparam int unsigned LEVELS = (N > 1) ? $clog2(N) : 0;
    localparam int unsigned LEAVES = 1 << LEVELS;
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    logic [W-1:0] node [NODES];

    genvar i;
    generate
        for (i = 0; i < LEAVES; i++) begin : g_leaf
            if (i < N) begin : g_used
                // mask a lane to zero unless its unit holds the grant
                assign node[LEAVES-1+i] = lanes[i*W +: W] & {W{sel[i]}};
            end else begin : g_pad
                // unused padding leaf contributes nothing
                assign node[LEAVES-1+i] = '0;
            end
        end
        for (i = 0; i < LEAVES - 1; i++) begin : g_inner
            // combine two children into their parent
            assign node[i] = node[2*i+1] | node[2*i+2];
        end
    endgenerate

    assign merged = node[0];
endmodule

// File: rtl/rp_reg_array.sv
// Module: behavioural register file with one read and one write port.
// Read is combinational; the write lands on the clock edge. Synchronous
// active-low reset clears every entry. Assumes: no read/write bypass is wanted.
module rp_reg_array #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [DATA_W-1:0] rd
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // store on write enable, clear the whole array on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    // asynchronous read of the addressed entry
    assign rd = mem[ra];
endmodule

// File: rtl/regport_share_arb.sv
// Module: shared register-port arbiter (top).
// One read bus and one write bus, each shared by N_UNITS execution units.
// A priority picker grants one unit per port; the granted unit's fields reach
// the bus through a masked OR tree. The read path is combinational. The write
// enable, address, data and per-unit go strobe are registered together.
// Assumes: only one unit operates at a time; no hazard checks, no bypass.
module regport_share_arb
    import regport_pkg::*;
#(
    parameter int unsigned N_UNITS = RP_N_UNITS,
    parameter int unsigned ADDR_W  = RP_ADDR_W,
    parameter int unsigned DATA_W  = RP_DATA_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_UNITS-1:0]          rd_req,
    input  logic [N_UNITS*ADDR_W-1:0]   rd_addr_in,
    output logic [N_UNITS-1:0]          rd_gnt,
    output logic                        rf_rd_en,
    output logic [ADDR_W-1:0]           rf_rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    input  logic [N_UNITS-1:0]          wr_req,
    input  logic [N_UNITS*ADDR_W-1:0]   wr_addr_in,
    input  logic [N_UNITS*DATA_W-1:0]   wr_data_in,
    output logic [N_UNITS-1:0]          wr_go,
    output logic                        rf_wr_en,
    output logic [ADDR_W-1:0]           rf_wr_addr,
    output logic [DATA_W-1:0]           rf_wr_data
);
    localparam int unsigned BEAT_W = ADDR_W + DATA_W;

    // ---------------- read port ----------------
    logic              rd_any;
    logic [DATA_W-1:0] rd_raw;

    rp_prio_pick #(.N(N_UNITS)) u_rd_pick (
        .req (rd_req),
        .gnt (rd_gnt),
        .any (rd_any)
    );

    rp_or_merge #(.N(N_UNITS), .W(ADDR_W)) u_rd_merge (
        .lanes  (rd_addr_in),
        .sel    (rd_gnt),
        .merged (rf_rd_addr)
    );

    assign rf_rd_en = rd_any;

    // ---------------- write port ----------------
    logic [N_UNITS-1:0]        wr_pick;
    logic                      wr_any;
    logic [N_UNITS*BEAT_W-1:0] wr_beats;
    logic [BEAT_W-1:0]         wr_beat;

    rp_prio_pick #(.N(N_UNITS)) u_wr_pick (
        .req (wr_req),
        .gnt (wr_pick),
        .any (wr_any)
    );

    genvar u;
    generate
        for (u = 0; u < N_UNITS; u++) begin : g_beat
            // pack each unit's address and data into one lane
            assign wr_beats[u*BEAT_W +: BEAT_W] =
                {wr_addr_in[u*ADDR_W +: ADDR_W], wr_data_in[u*DATA_W +: DATA_W]};
        end
    endgenerate

    rp_or_merge #(.N(N_UNITS), .W(BEAT_W)) u_wr_merge (
        .lanes  (wr_beats),
        .sel    (wr_pick),
        .merged (wr_beat)
    );

    // register enable, address, data and go strobe on one common edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_go      <= '0;
            rf_wr_en   <= 1'b0;
            rf_wr_addr <= '0;
            rf_wr_data <= '0;
        end else begin
            wr_go      <= wr_pick;
            rf_wr_en   <= wr_any;
            rf_wr_addr <= wr_beat[BEAT_W-1 -: ADDR_W];
            rf_wr_data <= wr_beat[DATA_W-1:0];
        end
    end

    // ---------------- register file ----------------
    rp_reg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_wr_en),
        .wa    (rf_wr_addr),
        .wd    (rf_wr_data),
        .ra    (rf_rd_addr),
        .rd    (rd_raw)
    );

    // drive zero onto the read bus when nobody holds the port
    assign rd_data = rf_rd_en ? rd_raw : '0;
endmodule

// File: rtl/rp_share_chk.sv
// Module: property checker for regport_share_arb, attached with bind.
// Assumes: synchronous active-low reset; checks only port-level relations.
module rp_share_chk #(
    parameter int unsigned N_UNITS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_UNITS-1:0] rd_req,
    input logic [N_UNITS-1:0] rd_gnt,
    input logic               rf_rd_en,
    input logic [N_UNITS-1:0] wr_req,
    input logic [N_UNITS-1:0] wr_go,
    input logic               rf_wr_en
);
    // R2
    rd_gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_gnt));
    // R2
    rd_gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt & ~rd_req) == '0);
    // R2
    rd_gnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req != '0) |-> (rd_gnt != '0));
    // R4
    rd_en_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en == (rd_gnt != '0));
    // R3
    wr_go_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_go));
    // R3
    wr_go_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go != '0) |-> (($past(wr_req) & wr_go) != '0));
    // R3
    wr_go_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(wr_req) != '0)) |-> (wr_go != '0));
    // R6
    wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en == (wr_go != '0));
endmodule

bind regport_share_arb rp_share_chk #(.N_UNITS(N_UNITS)) u_share_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_gnt   (rd_gnt),
    .rf_rd_en (rf_rd_en),
    .wr_req   (wr_req),
    .wr_go    (wr_go),
    .rf_wr_en (rf_wr_en)
);

// File: tb/regport_share_arb_tb.sv
// Bench: behavioural reference model compared against the DUT every clock.
module regport_share_arb_tb;
    localparam int N  = 4;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  rd_req = '0;
    logic [N*AW-1:0] rd_addr_in = '0;
    logic [N-1:0]  rd_gnt;
    logic          rf_rd_en;
    logic [AW-1:0] rf_rd_addr;
    logic [DW-1:0] rd_data;
    logic [N-1:0]  wr_req = '0;
    logic [N*AW-1:0] wr_addr_in = '0;
    logic [N*DW-1:0] wr_data_in = '0;
    logic [N-1:0]  wr_go;
    logic          rf_wr_en;
    logic [AW-1:0] rf_wr_addr;
    logic [DW-1:0] rf_wr_data;

    regport_share_arb #(.N_UNITS(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr_in(rd_addr_in), .rd_gnt(rd_gnt),
        .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr_in(wr_addr_in), .wr_data_in(wr_data_in),
        .wr_go(wr_go), .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr),
        .rf_wr_data(rf_wr_data)
    );

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    logic [N-1:0]  e_go;
    logic          e_en;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;

    function automatic int first_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // compare at mid-cycle, then advance model across the next rising edge
    task automatic step();
        int ri;
        int wi;
        logic [AW-1:0] ra;
        #1;
        ri = first_idx(rd_req);
        ra = (ri >= 0) ? rd_addr_in[ri*AW +: AW] : '0;
        chk("R2 rd_gnt", rd_gnt, (ri >= 0) ? (32'd1 << ri) : 32'd0);
        chk("R4 rf_rd_en", rf_rd_en, (ri >= 0));
        chk("R4/R8 rf_rd_addr", rf_rd_addr, ra);
        chk("R5/R7 rd_data", rd_data, (ri >= 0) ? ref_mem[ra] : '0);
        chk("R3 wr_go", wr_go, e_go);
        chk("R6 rf_wr_en", rf_wr_en, e_en);
        chk("R6/R8 rf_wr_addr", rf_wr_addr, e_addr);
        chk("R6/R8 rf_wr_data", rf_wr_data, e_data);
        @(posedge clk);
        if (e_en) ref_mem[e_addr] = e_data;
        wi = first_idx(wr_req);
        e_go   = (wi >= 0) ? (N'(1) << wi) : '0;
        e_en   = (wi >= 0);
        e_addr = (wi >= 0) ? wr_addr_in[wi*AW +: AW] : '0;
        e_data = (wi >= 0) ? wr_data_in[wi*DW +: DW] : '0;
        @(negedge clk);
    endtask

    task automatic set_wr(input int u, input int a, input logic [DW-1:0] d);
        wr_addr_in[u*AW +: AW] = AW'(a);
        wr_data_in[u*DW +: DW] = d;
    endtask

    initial begin
        logic [N-1:0] pend;
        for (int k = 0; k < DEPTH; k++) ref_mem[k] = '0;
        e_go = '0; e_en = 1'b0; e_addr = '0; e_data = '0;

        // R1: requests during reset must not reach the registered outputs
        wr_req = '1;
        for (int u = 0; u < N; u++) set_wr(u, u, 16'hA5A0 + DW'(u));
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk("R1 wr_go reset", wr_go, 0);
        chk("R1 rf_wr_en reset", rf_wr_en, 0);
        chk("R1 rf_wr_data reset", rf_wr_data, 0);
        wr_req = '0;
        rst_n = 1'b1;

        // R1/R5: every entry reads zero after reset, through each unit
        for (int k = 0; k < DEPTH; k++) begin
            rd_req = N'(1) << (k % N);
            rd_addr_in = '0;
            rd_addr_in[(k % N)*AW +: AW] = AW'(k);
            step();
        end
        rd_req = '0;

        // R6/R7: single writes by different units, then read back
        for (int k = 0; k < DEPTH; k++) begin
            wr_req = N'(1) << ((k + 1) % N);
            set_wr((k + 1) % N, k, 16'h1000 + DW'(k * 7));
            step();
        end
        wr_req = '0;
        step();
        for (int k = 0; k < DEPTH; k++) begin
            rd_req = '1;
            rd_addr_in = {N*AW{1'b1}};
            rd_addr_in[0 +: AW] = AW'(k);
            step();
        end
        rd_req = '0;

        // R7: write then read same register on the next two cycles
        wr_req = 4'b0010; set_wr(1, 5, 16'hBEEF);
        rd_req = 4'b0001; rd_addr_in[0 +: AW] = 3'd5;
        step();
        wr_req = '0;
        step();   // old content still visible here
        step();   // new content visible here
        rd_req = '0;

        // R9/R8: all units contend; each drops its request only once granted
        pend = '1;
        for (int u = 0; u < N; u++) set_wr(u, 2, 16'hC000 | DW'(u * 16'h0111));
        while (pend != '0) begin
            wr_req = pend;
            // scramble losers' data to expose any leak into the OR tree
            for (int u = 0; u < N; u++)
                if (u != first_idx(pend)) set_wr(u, $urandom % DEPTH, DW'($urandom));
            set_wr(first_idx(pend), 2, 16'hC000 | DW'(first_idx(pend) * 16'h0111));
            step();
            pend[first_idx(pend)] = 1'b0;
        end
        wr_req = '0;
        step();
        rd_req = 4'b1000; rd_addr_in[3*AW +: AW] = 3'd2;
        step();
        rd_req = '0;

        // R2/R3/R8: random traffic on both ports
        for (int c = 0; c < 600; c++) begin
            rd_req = N'($urandom);
            wr_req = N'($urandom);
            rd_addr_in = (N*AW)'($urandom);
            wr_addr_in = (N*AW)'($urandom);
            wr_data_in = {$urandom, $urandom};
            step();
        end
        rd_req = '0; wr_req = '0;
        step();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failure
    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule